// File: doc/BRIEF.md
# Byte-Lane Pipelined Synchronous SRAM

This block is a single-port synchronous memory with 32-bit words and a configurable depth. On every rising clock edge it captures the address, the write data and all control inputs. One edge later it either commits a write or loads a read result into an output register. The shared data bus is split into a write-data port and a read-data port. A valid flag marks each cycle in which the read-data port carries a fresh word.

A write can update any subset of the four byte lanes. The lanes are selected by active-low per-lane enables, and those enables count only while the active-low lane-write strobe is low. An active-low whole-word write strobe overrides all of this and writes every lane. Three chip selects, two active-low and one active-high, gate every access so that several such memories can share one bus. The address of each access is supplied from outside, so burst sequencing belongs to the surrounding logic.

Top module: `sync_sram_bw`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rdata` becomes 0 and `rvalid` becomes 0.
- R2: A read presented before edge k gives the word at that address on `rdata` with `rvalid` high after edge k+1. Reads issued on consecutive cycles return their words on consecutive cycles, in order.
- R3: With `all_wr_n` high and `lane_wr_n` low, each lane whose enable is low is written. `lane_en_n[0]` selects bits 7:0, `[1]` selects bits 15:8, `[2]` selects bits 23:16 and `[3]` selects bits 31:24. The other lanes keep their contents.
- R4: With `all_wr_n` and `lane_wr_n` both high, the cycle is a read and `lane_en_n` has no effect on the memory.
- R5: With `all_wr_n` low, all four lanes are written, whatever the values of `lane_wr_n` and `lane_en_n`.
- R6: The memory is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. In a deselected cycle nothing is written, `rdata` holds its value and `rvalid` is low one cycle later.
- R7: A selected write cycle does not load `rdata`. One cycle later `rvalid` is low and `rdata` holds its previous value.
- R8: A read presented in the cycle right after a write to the same address returns the newly written data.
- R9: With `lane_wr_n` low, `all_wr_n` high and every `lane_en_n` bit high, the cycle writes nothing and does not load `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the control and output registers |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| wdata | input | 32 | Write data |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Whole-word write strobe, active low |
| lane_wr_n | input | 1 | Lane-write strobe that qualifies the lane enables, active low |
| lane_en_n | input | 4 | Per-lane write enables, active low |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | High while rdata holds a read issued two edges earlier |

## Verification
The inputs of a cycle are captured at one edge, and their result appears after the next edge. A read word and its valid flag are therefore due after the second edge from the stimulus, and a write's effect can be seen by a read issued in the very next cycle. The bench changes inputs on falling edges and samples outputs on falling edges. Each check sits at the falling edge two rising edges after the stimulus it judges. Back-to-back reads are compared one cycle behind their issue against a scoreboard.

// File: rtl/sync_sram_bw.sv
`timescale 1ns/1ps
module sync_sram_bw #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          cs0_n,
  input  logic          cs1,
  input  logic          cs2_n,
  input  logic          all_wr_n,
  input  logic          lane_wr_n,
  input  logic [3:0]    lane_en_n,
  output logic [31:0]   rdata,
  output logic          rvalid
);
  localparam int NL = 4;

  logic          sel, rd;
  logic [NL-1:0] wmask;
  logic [AW-1:0] addr_q;
  logic [31:0]   wdata_q, rd_word;
  logic [NL-1:0] wmask_q;
  logic          rd_q;

  assign sel   = !cs0_n && cs1 && !cs2_n;
  assign rd    = sel && all_wr_n && lane_wr_n;
  assign wmask = !sel      ? '0 :
                 !all_wr_n ? '1 :
                 !lane_wr_n ? ~lane_en_n : '0;

  always_ff @(posedge clk) begin
    addr_q  <= addr;
    wdata_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wmask_q <= '0;
      rd_q    <= 1'b0;
      rvalid  <= 1'b0;
      rdata   <= '0;
    end else begin
      wmask_q <= wmask;
      rd_q    <= rd;
      rvalid  <= rd_q;
      if (rd_q) rdata <= rd_word;
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [7:0] ram [DEPTH];
    always_ff @(posedge clk)
      if (wmask_q[g]) ram[addr_q] <= wdata_q[8*g +: 8];
    assign rd_word[8*g +: 8] = ram[addr_q];
  end
endmodule

module sync_sram_bw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs0_n,
  input logic        cs1,
  input logic        cs2_n,
  input logic        all_wr_n,
  input logic        lane_wr_n,
  input logic [3:0]  lane_en_n,
  input logic [31:0] rdata,
  input logic        rvalid,
  input logic [3:0]  wmask_q
);
  logic on, p1, p2;
  assign on = !cs0_n && cs1 && !cs2_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p1 <= 1'b0;
      p2 <= 1'b0;
    end else begin
      p1 <= on && all_wr_n && lane_wr_n;
      p2 <= p1;
    end
  end

  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid == p2);
  assert_lane_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (on && all_wr_n && !lane_wr_n) |=> wmask_q == ~$past(lane_en_n));
  assert_read_nowr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (on && all_wr_n && lane_wr_n) |=> wmask_q == 4'h0);
  assert_word_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !all_wr_n) |=> wmask_q == 4'hF);
  assert_desel_nowr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> wmask_q == 4'h0);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !p1 |=> $stable(rdata));
  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (on && (!all_wr_n || !lane_wr_n)) |=> ##1 ($stable(rdata) && !rvalid));
endmodule

bind sync_sram_bw sync_sram_bw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
  .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_en_n(lane_en_n),
  .rdata(rdata), .rvalid(rvalid), .wmask_q(wmask_q)
);

// File: tb/test_sync_sram_bw.sv
`timescale 1ns/1ps
module test_sync_sram_bw;
  localparam int DEPTH = 1024;
  localparam int AW = $clog2(DEPTH);
  localparam int NA = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic          cs0_n, cs1, cs2_n, all_wr_n, lane_wr_n;
  logic [3:0]    lane_en_n;
  logic [31:0]   rdata;
  logic          rvalid;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] sb [NA];

  always #2.5 clk = ~clk;

  sync_sram_bw #(.DEPTH(DEPTH)) i_sync_sram_bw (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .all_wr_n(all_wr_n),
    .lane_wr_n(lane_wr_n), .lane_en_n(lane_en_n), .rdata(rdata), .rvalid(rvalid));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  // sets inputs at the current falling edge, returns at the next one
  task automatic drive(logic [AW-1:0] a, logic [31:0] d, logic c0n, logic c1,
                       logic c2n, logic awn, logic lwn, logic [3:0] len);
    addr = a; wdata = d; cs0_n = c0n; cs1 = c1; cs2_n = c2n;
    all_wr_n = awn; lane_wr_n = lwn; lane_en_n = len;
    @(negedge clk);
  endtask

  task automatic idle();
    drive('0, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0);
  endtask

  task automatic wr(int a, logic [31:0] d, logic awn, logic lwn, logic [3:0] len);
    drive(AW'(a), d, 1'b0, 1'b1, 1'b0, awn, lwn, len);
    if (!awn) sb[a] = d;
    else if (!lwn) sb[a] = merge(sb[a], d, ~len);
  endtask

  task automatic rd_check(string req, int a);
    drive(AW'(a), $urandom, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'($urandom));
    idle();
    check(req, {31'h0, rvalid}, 32'h1);
    check(req, rdata, sb[a]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(); idle(); idle();
    check("R1 rdata", rdata, 32'h0);
    check("R1 rvalid", {31'h0, rvalid}, 32'h0);
    rst_n = 1'b1;
    idle();
  endtask

  task automatic t_word_write();
    for (int a = 0; a < NA; a++)
      wr(a, $urandom, 1'b0, 1'($urandom), 4'($urandom));
    for (int a = 0; a < NA; a++) rd_check("R5", a);
  endtask

  task automatic t_lanes();
    for (int i = 0; i < 4; i++) begin
      wr(i, 32'hA5A5_A5A5 ^ (32'h11 << (8 * i)), 1'b1, 1'b0, ~(4'b1 << i));
      rd_check("R3 single lane", i);
    end
    for (int k = 0; k < 8; k++) begin
      int a = 4 + k;
      wr(a, $urandom, 1'b1, 1'b0, 4'($urandom));
      rd_check("R3 lane mask", a);
    end
  endtask

  task automatic t_read_ignores_lanes();
    drive(AW'(3), ~sb[3], 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0);
    idle();
    check("R4 read data", rdata, sb[3]);
    rd_check("R4 unchanged", 3);
  endtask

  task automatic t_no_lanes();
    logic [31:0] prev;
    rd_check("R9 setup", 5);
    prev = rdata;
    wr(5, ~sb[5], 1'b1, 1'b0, 4'hF);
    idle();
    check("R9 rvalid", {31'h0, rvalid}, 32'h0);
    check("R9 rdata hold", rdata, prev);
    rd_check("R9 unchanged", 5);
  endtask

  task automatic t_deselect();
    logic [31:0] prev;
    for (int c = 0; c < 3; c++) begin
      rd_check("R6 setup", 6);
      prev = rdata;
      drive(AW'(6), ~sb[6], c == 0, c != 1, c == 2, 1'b0, 1'b0, 4'h0);
      drive(AW'(6), 32'h0, c == 0, c != 1, c == 2, 1'b1, 1'b1, 4'h0);
      check("R6 rvalid", {31'h0, rvalid}, 32'h0);
      check("R6 rdata hold", rdata, prev);
      idle();
      check("R6 rvalid rd", {31'h0, rvalid}, 32'h0);
      rd_check("R6 no write", 6);
    end
  endtask

  task automatic t_write_hold();
    logic [31:0] old7 = sb[7];
    drive(AW'(7), 32'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF);
    wr(8, $urandom, 1'b0, 1'b1, 4'hF);
    check("R7 prior read", rdata, old7);
    idle();
    check("R7 rvalid", {31'h0, rvalid}, 32'h0);
    check("R7 rdata hold", rdata, old7);
  endtask

  task automatic t_raw();
    wr(9, $urandom, 1'b1, 1'b0, 4'b0101);
    drive(AW'(9), 32'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0);
    idle();
    check("R8 rvalid", {31'h0, rvalid}, 32'h1);
    check("R8 read after write", rdata, sb[9]);
  endtask

  task automatic t_pipe();
    int a_prev = 0;
    for (int i = 0; i <= NA; i++) begin
      int a = (i * 7) % NA;
      if (i < NA) drive(AW'(a), 32'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0);
      else idle();
      if (i >= 1) begin
        check("R2 pipe rvalid", {31'h0, rvalid}, 32'h1);
        check("R2 pipe data", rdata, sb[a_prev]);
      end
      a_prev = a;
    end
  endtask

  task automatic t_random();
    for (int i = 0; i < 60; i++) begin
      int a = int'($urandom % NA);
      case ($urandom % 3)
        0: wr(a, $urandom, 1'b0, 1'($urandom), 4'($urandom));
        1: wr(a, $urandom, 1'b1, 1'b0, 4'($urandom));
        default: rd_check("R2 R3 R5 random", a);
      endcase
    end
    for (int a = 0; a < NA; a++) rd_check("R3 R5 final", a);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    addr = '0; wdata = '0; cs0_n = 1'b1; cs1 = 1'b0; cs2_n = 1'b1;
    all_wr_n = 1'b1; lane_wr_n = 1'b1; lane_en_n = 4'hF;
    @(negedge clk);
    t_reset();
    t_word_write();
    t_lanes();
    t_read_ignores_lanes();
    t_no_lanes();
    t_deselect();
    t_write_hold();
    t_raw();
    t_pipe();
    t_random();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule